// File: doc/BRIEF.md
# Multi-Target Configuration Load Controller

This block sits on the device side of a 16-bit host register bus and steers configuration bitstreams into one of up to three programmable targets. The host writes a control register to pick a target and walk it through a fixed sequence. The sequence is select, hold in reset until the target acknowledges, release, and then stream words. Each 16-bit word written to the data register is handed to the selected target over a valid/busy handshake. The host learns when the next step is allowed by polling a status register.

Each target is a simple word sink. It raises an acknowledge while it is held in reset and ready for configuration. It raises busy while it cannot take a word. A control write with the active bit clear ends the session. A reset-acknowledge watchdog turns a target that never answers into an error flag. It does not leave the host polling forever. A separate mask register holds one bit per target and is presented on an output.

Top module: `cfg_load_ctrl`

## Requirements
- R1: After synchronous reset the sequencer is idle: status reads 0x0, no target is selected or held in reset, `tgt_valid` is low and the mask output is all ones.
- R2: Register decode uses offsets 0x100 for control (reads back the last written low byte), 0x104 for status, 0x108 for data (reads 0) and 0x10c for mask (reads the mask in the low bits). Any other offset reads 0.
- R3: A control write of 0xC0|i with i in 0..2 selects target i one-hot on `tgt_sel` and holds `tgt_rst` bit i high. Status reads 0x0 until the target's acknowledge is sampled at a clock edge, and from then on it reads 0x2 (status bit 1 = ready).
- R4: A control write of 0x80|i releases reset and keeps target i selected. Status then reads exactly 0x3: bit 0 means selected and out of reset, and bit 1 means a word may be written.
- R5: While status reads 0x3, a data write sets `tgt_valid` from the next cycle with `tgt_word` equal to the written value, first stream byte in bits 7:0. Status bit 1 stays low and the word stays stable until a clock edge where the selected target's busy bit is low. Status bit 1 rises after that edge.
- R6: A data write made while status bit 1 is low, or outside the streaming state, is ignored: `tgt_valid` and `tgt_word` are unchanged. It also sets a sticky overrun flag in status bit 4, and any control write clears that flag.
- R7: If a target held in reset gives no acknowledge for TIMEOUT cycles, status bit 5 is set and the target is deselected. Any control write clears the flag.
- R8: A control write with bit 7 clear (including 0x0), or with target index 3, returns the sequencer to idle. It deselects all targets, releases reset and drops any pending word.
- R9: A write to the mask register loads one mask bit per target onto `mask_o`. A write of 0 clears them all.
- R10: A reset with no data (select and reset, acknowledge, release, then control 0x0) leaves every target deselected and out of reset, with status 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from `bus_addr` |
| tgt_ack | input | 3 | Per-target reset acknowledge |
| tgt_busy | input | 3 | Per-target busy; a word is taken at an edge where the selected bit is low |
| tgt_sel | output | 3 | One-hot target select |
| tgt_rst | output | 3 | Per-target reset hold |
| tgt_valid | output | 1 | Word pending toward the selected target |
| tgt_word | output | 16 | Configuration word |
| mask_o | output | 3 | Target mask bits |

## Verification
Every register write takes effect at the edge that samples the strobe. Its effect on status and the target outputs is checked one cycle later, at the following falling edge. A reset acknowledge adds one more edge before status shows 0x2. A word handed over to an idle target is taken one edge after it appears, so the table-driven part of the bench reads status two cycles after each write. In that sampling both cases have already settled. The directed tests count edges exactly. The busy hold, the overrun and the TIMEOUT-cycle watchdog are each sampled once on the last cycle before the change and once on the first cycle after it.

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl #(
  parameter int NT      = 3,
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter int TIMEOUT = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wen,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NT-1:0] tgt_ack,
  input  logic [NT-1:0] tgt_busy,
  output logic [NT-1:0] tgt_sel,
  output logic [NT-1:0] tgt_rst,
  output logic          tgt_valid,
  output logic [DW-1:0] tgt_word,
  output logic [NT-1:0] mask_o
);
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [AW-1:0] A_CTRL = AW'('h100);
  localparam logic [AW-1:0] A_STAT = AW'('h104);
  localparam logic [AW-1:0] A_DATA = AW'('h108);
  localparam logic [AW-1:0] A_MASK = AW'('h10c);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_ACK, S_RUN} state_t;

  state_t        state;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [7:0]    ctrl_q;
  logic          pend, ovr, err;
  logic [NT-1:0] sel_oh;
  logic [DW-1:0] status;

  wire wr_ctrl = bus_wen && (bus_addr == A_CTRL);
  wire wr_data = bus_wen && (bus_addr == A_DATA);
  wire wr_mask = bus_wen && (bus_addr == A_MASK);
  wire [IW-1:0] new_idx = bus_wdata[IW-1:0];
  wire idx_ok   = 32'(new_idx) < NT;
  wire ack_sel  = |(tgt_ack & sel_oh);
  wire busy_sel = |(tgt_busy & sel_oh);
  wire ready    = (state == S_ACK) || (state == S_RUN && !pend);

  assign sel_oh    = (state == S_IDLE) ? '0 : NT'(1) << idx;
  assign tgt_sel   = sel_oh;
  assign tgt_rst   = (state == S_RST || state == S_ACK) ? sel_oh : '0;
  assign tgt_valid = pend;
  assign status    = {{(DW-6){1'b0}}, err, ovr, 2'b00, ready, state == S_RUN};

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl_q);
      A_STAT:  bus_rdata = status;
      A_MASK:  bus_rdata = DW'(mask_o);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; idx <= '0; cnt <= '0; ctrl_q <= '0;
      pend <= 1'b0; ovr <= 1'b0; err <= 1'b0;
      tgt_word <= '0; mask_o <= '1;
    end else begin
      if (wr_mask) mask_o <= bus_wdata[NT-1:0];
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata[7:0];
        ovr <= 1'b0; err <= 1'b0; pend <= 1'b0; cnt <= '0;
        if (bus_wdata[7] && idx_ok) begin
          idx   <= new_idx;
          state <= bus_wdata[6] ? S_RST : S_RUN;
        end else begin
          state <= S_IDLE;
        end
      end else begin
        case (state)
          S_RST:
            if (ack_sel) state <= S_ACK;
            else if (cnt == CW'(TIMEOUT - 1)) begin
              err <= 1'b1; state <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_RUN:
            if (pend && !busy_sel) pend <= 1'b0;
          default: ;
        endcase
        if (wr_data) begin
          if (state == S_RUN && !pend) begin
            pend <= 1'b1; tgt_word <= bus_wdata;
          end else ovr <= 1'b1;
        end
      end
    end
  end

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));
  assert_valid_selected_R5: assert property (@(posedge clk) disable iff (rst)
    tgt_valid |-> (|tgt_sel) && (tgt_rst == '0));
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (rst)
    tgt_valid && (|(tgt_busy & tgt_sel)) && !wr_ctrl |=> tgt_valid && $stable(tgt_word));
  assert_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    wr_data && !bus_rdata[1] && bus_addr == A_DATA && !status[1] |=> status[4]);
  assert_end_idle_R8: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && !bus_wdata[7] |=> tgt_sel == '0 && tgt_rst == '0 && !tgt_valid);
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> mask_o == $past(bus_wdata[NT-1:0]));
endmodule

// File: tb/sim_cfg_load_ctrl.sv
module sim_cfg_load_ctrl;
  localparam int TMO = 1000;
  localparam int NV  = 13;
  localparam logic [43:0] VEC [NV] = '{
    {12'h100, 16'h00C0, 16'h0002},
    {12'h100, 16'h0080, 16'h0003},
    {12'h108, 16'h3412, 16'h0003},
    {12'h108, 16'hBEEF, 16'h0003},
    {12'h100, 16'h0000, 16'h0000},
    {12'h100, 16'h00C2, 16'h0002},
    {12'h100, 16'h0082, 16'h0003},
    {12'h108, 16'h0001, 16'h0003},
    {12'h100, 16'h0000, 16'h0000},
    {12'h108, 16'h1111, 16'h0010},
    {12'h100, 16'h00C1, 16'h0002},
    {12'h100, 16'h0081, 16'h0003},
    {12'h100, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wen = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [2:0] tgt_ack, tgt_busy = '0, tgt_sel, tgt_rst, mask_o;
  logic tgt_valid, ack_en = 1'b1;
  logic [15:0] tgt_word, got_word = '0;
  logic [2:0] got_sel = '0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  assign tgt_ack = tgt_rst & {3{ack_en}};

  cfg_load_ctrl #(.TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_ack(tgt_ack),
    .tgt_busy(tgt_busy), .tgt_sel(tgt_sel), .tgt_rst(tgt_rst),
    .tgt_valid(tgt_valid), .tgt_word(tgt_word), .mask_o(mask_o));

  always @(posedge clk)
    if (!rst && tgt_valid && (tgt_busy & tgt_sel) == 3'b000) begin
      got_word <= tgt_word; got_sel <= tgt_sel;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic stat(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(12'h104, v); chk(req, 32'(v), 32'(exp));
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    stat("R1 status", 16'h0000);
    chk("R1 outputs", {tgt_sel, tgt_rst, tgt_valid}, 0);
    chk("R1 mask", 32'(mask_o), 32'h7);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][43:32], VEC[k][31:16]);
      @(negedge clk);
      stat($sformatf("R3/R4/R5/R6/R8 vector %0d", k), VEC[k][15:0]);
    end
    chk("R5 last word to target 2", {got_sel, got_word}, {3'b100, 16'h0001});

    // R3 status before acknowledge, R5 byte order and busy hold, R6 overrun
    wr(12'h100, 16'h00C1);
    stat("R3 before ack", 16'h0000);
    chk("R3 select/reset", {tgt_sel, tgt_rst}, {3'b010, 3'b010});
    @(negedge clk);
    stat("R3 acked", 16'h0002);
    wr(12'h100, 16'h0081);
    stat("R4 released", 16'h0003);
    chk("R4 reset low", 32'(tgt_rst), 0);
    tgt_busy = 3'b010;
    wr(12'h108, 16'h3412);
    stat("R5 taking word", 16'h0001);
    chk("R5 first byte low", 32'(tgt_word[7:0]), 32'h12);
    wr(12'h108, 16'h0BAD);
    stat("R6 overrun while busy", 16'h0011);
    chk("R6 word kept", {tgt_valid, tgt_word}, {1'b1, 16'h3412});
    tgt_busy = 3'b000;
    @(negedge clk);
    stat("R5 accepted", 16'h0013);
    chk("R5 accepted word", {got_sel, got_word}, {3'b010, 16'h3412});
    wr(12'h100, 16'h0081);
    stat("R6 cleared by control", 16'h0003);

    // R8 index 3 ends session
    wr(12'h100, 16'h0083);
    stat("R8 index 3", 16'h0000);
    chk("R8 deselect", {tgt_sel, tgt_rst, tgt_valid}, 0);

    // R10 reset without data
    wr(12'h100, 16'h00C2);
    @(negedge clk);
    wr(12'h100, 16'h0082);
    wr(12'h100, 16'h0000);
    stat("R10 status", 16'h0000);
    chk("R10 outputs", {tgt_sel, tgt_rst}, 0);

    // R7 acknowledge timeout
    ack_en = 1'b0;
    wr(12'h100, 16'h00C0);
    repeat (TMO - 1) @(negedge clk);
    stat("R7 before timeout", 16'h0000);
    chk("R7 still held", 32'(tgt_rst), 32'h1);
    @(negedge clk);
    stat("R7 timeout flag", 16'h0020);
    chk("R7 deselected", {tgt_sel, tgt_rst}, 0);
    ack_en = 1'b1;
    wr(12'h100, 16'h0000);
    stat("R7 cleared", 16'h0000);

    // R2 decode, R9 mask
    wr(12'h100, 16'h0040);
    rd(12'h100, v); chk("R2 control readback", 32'(v), 32'h40);
    rd(12'h108, v); chk("R2 data reads 0", 32'(v), 0);
    rd(12'h110, v); chk("R2 unmapped", 32'(v), 0);
    wr(12'h10c, 16'h0005);
    chk("R9 mask out", 32'(mask_o), 32'h5);
    rd(12'h10c, v); chk("R2 mask readback", 32'(v), 32'h5);
    wr(12'h10c, 16'h0000);
    chk("R9 mask cleared", 32'(mask_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule